// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side sequencer that carries an interrupt from acceptance to the first fetch of its handler. It waits for the instruction in progress to finish, then writes the return address and the condition flags onto a downward-growing, word-wide stack. It then fetches the handler address from a vector table and hands the new program counter and the flags, with the global mask bit set, back to the core. A return-from-exception request runs the same path in reverse. The flags come off the stack first, then the return address, and the interrupted program resumes.

All memory traffic goes through one word-wide request/ready port, so the block works with wait-stated memory. The stack pointer is held inside the block. The core can load it while the sequencer is idle. Any sequence that starts with an odd pointer clears the low bit and raises a sticky alignment error.

Top module: `irq_seq_top`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows. `busy`, `mem_req`, `pc_load`, `ccr_load`, `irq_ack` and `align_err` are 0. `pc_out` and `ccr_out` are 0, and `sp_out` equals the `SP_RESET` parameter.
- R2: `irq_ack` is high only in an idle cycle in which `irq_req` and `insn_done` are both high and `rte_req` is low. That cycle starts the entry sequence. `ack_vec` carries `irq_vec` while `irq_ack` is high and is 0 otherwise.
- R3: The first entry access is a write (`mem_we`=1) at the aligned stack pointer minus 2. Its data is the `pc_in` value captured in the acknowledge cycle.
- R4: The second entry access writes `ccr_in`, captured at acknowledge and zero-extended, at the aligned stack pointer minus 4. `sp_out` holds that address when entry completes.
- R5: The third entry access is a read at `VEC_BASE + 2*vector`. The cycle after it completes, `pc_out` holds the word read and `pc_load` is high for one cycle.
- R6: In that same cycle `ccr_load` is high and `ccr_out` is the captured flags with bit `IBIT` (default 7) forced to 1.
- R7: `rte_req` high in an idle cycle starts a return, and it takes priority over a same-cycle interrupt. The return reads the flags (low `CW` bits) at the aligned pointer and then the return address at pointer+2. The cycle after the second read, `pc_out`, `ccr_out`, `pc_load` and `ccr_load` present them, and the pointer has grown by 4.
- R8: A sequence that starts with `sp_out[0]`=1 sets `align_err`, which stays high until reset, and clears the low bit before the first access. Every memory access address is even.
- R9: While `mem_req` is high and `mem_rdy` is low, address, write enable and write data stay unchanged and the stack pointer does not move. `mem_rdy` has no effect when no access is pending.
- R10: `sp_wr` loads `sp_wdata` into the stack pointer only in an idle cycle that starts no sequence. At all other times it is ignored.
- R11: `busy` is high from the cycle after a sequence starts until the cycle in which `pc_load` pulses. A new sequence may start in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | An arbitrated interrupt is waiting |
| irq_vec | input | VW | Vector number of the waiting interrupt |
| insn_done | input | 1 | The current instruction completes this cycle |
| rte_req | input | 1 | Return-from-exception request |
| irq_ack | output | 1 | Interrupt taken this cycle |
| ack_vec | output | VW | Vector number being acknowledged |
| pc_in | input | AW | Address of the next instruction to run |
| ccr_in | input | CW | Current condition flags |
| pc_out | output | AW | New program counter |
| pc_load | output | 1 | Load strobe for pc_out |
| ccr_out | output | CW | New condition flags |
| ccr_load | output | 1 | Load strobe for ccr_out |
| sp_wr | input | 1 | Stack pointer write strobe |
| sp_wdata | input | AW | Stack pointer write value |
| sp_out | output | AW | Current stack pointer |
| align_err | output | 1 | Sticky odd-stack-pointer flag |
| busy | output | 1 | A sequence is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word access address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data |
| mem_rdy | input | 1 | Access completes this cycle |

## Verification
Wait states are inserted at random densities. A design that moved the pointer or changed the address before the ready cycle would write stack words to the wrong place, and the return would then restore garbage. Cycles that raise `rte_req` together with an interrupt check that the return wins. Pointer writes aimed at busy cycles and start cycles must leave `sp_out` untouched. Odd pointer values check both the sticky flag and the cleared low bit, and an unaligned push would show up as a wrong address. Returns run against the stack the bench memory built, so a swapped push or pop order shows up as exchanged PC and flag values.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
package irq_seq_pkg;

    // Sequencer phases; one memory access per non-idle phase.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CCR,
        ST_VEC_RD,
        ST_POP_CCR,
        ST_POP_PC
    } seq_state_t;

    // Stack pointer update commands issued by the controller.
    typedef enum logic [2:0] {
        SP_KEEP,
        SP_LOAD,
        SP_ENTRY,
        SP_DEC,
        SP_ALIGN,
        SP_INC
    } sp_op_t;

endpackage

// File: rtl/irq_seq_sp.sv
// Stack pointer register with alignment check.
// Does: applies one update command per cycle (load, align, align-and-
// decrement, decrement, increment) in word steps of 2 and keeps a sticky
// flag when a sequence starts from an odd address.
// Assumes: the controller issues SP_ENTRY/SP_ALIGN only when a sequence starts.
module irq_seq_sp
    import irq_seq_pkg::*;
#(
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   SP_RESET = 16'h0400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sp_op_t        op,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] sp,
    output logic          err
);

    localparam logic [AW-1:0] STEP = AW'(2);

    logic [AW-1:0] sp_even;

    // Pointer with its low bit cleared.
    always_comb sp_even = {sp[AW-1:1], 1'b0};

    // Pointer and sticky error update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= SP_RESET;
            err <= 1'b0;
        end else begin
            case (op)
                SP_LOAD:  sp <= wdata;
                SP_ENTRY: begin
                    sp  <= sp_even - STEP;
                    err <= err | sp[0];
                end
                SP_ALIGN: begin
                    sp  <= sp_even;
                    err <= err | sp[0];
                end
                SP_DEC:   sp <= sp - STEP;
                SP_INC:   sp <= sp + STEP;
                default:  sp <= sp;
            endcase
        end
    end

endmodule

// File: rtl/irq_seq_ctrl.sv
// Entry/return sequencing state machine.
// Does: accepts an interrupt at an instruction boundary, pushes the return
// address then the flags, reads the vector and presents the new PC and
// masked flags; for a return, pops flags then PC. One word access per phase.
// Assumes: the memory port completes an access in the cycle mem_rdy is high;
// VEC_BASE is even.
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            CW       = 8,
    parameter int            VW       = 6,
    parameter int            IBIT     = 7,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    input  logic          insn_done,
    input  logic          rte_req,
    input  logic          sp_wr,
    input  logic [AW-1:0] pc_in,
    input  logic [CW-1:0] ccr_in,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_rdy,
    output logic          irq_ack,
    output logic [VW-1:0] ack_vec,
    output sp_op_t        sp_op,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    output logic [AW-1:0] pc_out,
    output logic          pc_load,
    output logic [CW-1:0] ccr_out,
    output logic          ccr_load,
    output logic          busy
);

    localparam logic [CW-1:0] MASK_BIT = CW'(1) << IBIT;

    seq_state_t    state;
    logic [AW-1:0] pc_save;
    logic [CW-1:0] ccr_save;
    logic [VW-1:0] vec_save;
    logic [AW-1:0] vec_addr;
    logic          start_rte;
    logic          start_irq;

    // Sequence start decisions; a return outranks an interrupt.
    always_comb begin
        start_rte = (state == ST_IDLE) && rte_req;
        start_irq = (state == ST_IDLE) && !rte_req && irq_req && insn_done;
        irq_ack   = start_irq;
        ack_vec   = start_irq ? irq_vec : '0;
        busy      = (state != ST_IDLE);
        vec_addr  = VEC_BASE + (AW'(vec_save) << 1);
    end

    // Stack pointer command for this cycle.
    always_comb begin
        sp_op = SP_KEEP;
        case (state)
            ST_IDLE: begin
                if (start_rte)      sp_op = SP_ALIGN;
                else if (start_irq) sp_op = SP_ENTRY;
                else if (sp_wr)     sp_op = SP_LOAD;
            end
            ST_PUSH_PC: if (mem_rdy) sp_op = SP_DEC;
            ST_POP_CCR: if (mem_rdy) sp_op = SP_INC;
            ST_POP_PC:  if (mem_rdy) sp_op = SP_INC;
            default:    sp_op = SP_KEEP;
        endcase
    end

    // Memory port drive, held by the state until ready.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = pc_save;
            end
            ST_PUSH_CCR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = AW'(ccr_save);
            end
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_POP_CCR, ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = sp;
            end
            default: ;
        endcase
    end

    // Phase sequencing, capture registers and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pc_save  <= '0;
            ccr_save <= '0;
            vec_save <= '0;
            pc_out   <= '0;
            ccr_out  <= '0;
            pc_load  <= 1'b0;
            ccr_load <= 1'b0;
        end else begin
            pc_load  <= 1'b0;
            ccr_load <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_rte) begin
                        state <= ST_POP_CCR;
                    end else if (start_irq) begin
                        state    <= ST_PUSH_PC;
                        pc_save  <= pc_in;
                        ccr_save <= ccr_in;
                        vec_save <= irq_vec;
                    end
                end
                ST_PUSH_PC:  if (mem_rdy) state <= ST_PUSH_CCR;
                ST_PUSH_CCR: if (mem_rdy) state <= ST_VEC_RD;
                ST_VEC_RD: begin
                    if (mem_rdy) begin
                        pc_out   <= mem_rdata;
                        ccr_out  <= ccr_save | MASK_BIT;
                        pc_load  <= 1'b1;
                        ccr_load <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_POP_CCR: begin
                    if (mem_rdy) begin
                        ccr_save <= mem_rdata[CW-1:0];
                        state    <= ST_POP_PC;
                    end
                end
                ST_POP_PC: begin
                    if (mem_rdy) begin
                        pc_out   <= mem_rdata;
                        ccr_out  <= ccr_save;
                        pc_load  <= 1'b1;
                        ccr_load <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_seq_top.sv
// Interrupt entry and return sequencer, top level.
// Does: joins the sequencing controller to the stack pointer unit and
// exposes the core-side and memory-side ports.
// Assumes: one word access outstanding at a time; single clock domain.
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            CW       = 8,
    parameter int            VW       = 6,
    parameter int            IBIT     = 7,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter logic [AW-1:0] SP_RESET = 16'h0400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    input  logic          insn_done,
    input  logic          rte_req,
    output logic          irq_ack,
    output logic [VW-1:0] ack_vec,
    input  logic [AW-1:0] pc_in,
    input  logic [CW-1:0] ccr_in,
    output logic [AW-1:0] pc_out,
    output logic          pc_load,
    output logic [CW-1:0] ccr_out,
    output logic          ccr_load,
    input  logic          sp_wr,
    input  logic [AW-1:0] sp_wdata,
    output logic [AW-1:0] sp_out,
    output logic          align_err,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_rdy
);

    sp_op_t sp_op;

    irq_seq_ctrl #(
        .AW(AW), .CW(CW), .VW(VW), .IBIT(IBIT), .VEC_BASE(VEC_BASE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .irq_vec(irq_vec), .insn_done(insn_done),
        .rte_req(rte_req), .sp_wr(sp_wr),
        .pc_in(pc_in), .ccr_in(ccr_in), .sp(sp_out),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .irq_ack(irq_ack), .ack_vec(ack_vec), .sp_op(sp_op),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata),
        .pc_out(pc_out), .pc_load(pc_load),
        .ccr_out(ccr_out), .ccr_load(ccr_load), .busy(busy)
    );

    irq_seq_sp #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
        .clk(clk), .rst_n(rst_n), .op(sp_op), .wdata(sp_wdata),
        .sp(sp_out), .err(align_err)
    );

endmodule

// File: rtl/irq_seq_chk.sv
// Protocol checker for the sequencer, bound to the top level.
// Does: checks acknowledge timing, request stability, even addressing,
// masked flags on entry and the sticky error.
module irq_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_ack,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic          mem_rdy,
    input logic          pc_load,
    input logic          ccr_load,
    input logic          entry_mask,
    input logic          align_err,
    input logic [AW-1:0] sp_out
);

    logic in_entry;

    // Remembers whether the sequence in flight is an interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_entry <= 1'b0;
        else if (irq_ack) in_entry <= 1'b1;
        else if (pc_load) in_entry <= 1'b0;
    end

    p_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !busy);

    p_ack_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> busy);

    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_sp_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rdy) |=> $stable(sp_out));

    p_even_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && in_entry) |-> entry_mask);

    p_load_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ccr_load);

endmodule

bind irq_seq_top irq_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
    .pc_load(pc_load), .ccr_load(ccr_load), .entry_mask(ccr_out[IBIT]),
    .align_err(align_err), .sp_out(sp_out)
);

// File: tb/tb_irq_seq_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped every clock and compared
// against every output of the sequencer.
module tb_irq_seq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req, insn_done, rte_req, sp_wr, mem_rdy;
    logic [5:0]  irq_vec;
    logic [15:0] pc_in, sp_wdata, mem_rdata;
    logic [7:0]  ccr_in;
    logic        irq_ack, pc_load, ccr_load, align_err, busy, mem_req, mem_we;
    logic [5:0]  ack_vec;
    logic [15:0] pc_out, sp_out, mem_addr, mem_wdata;
    logic [7:0]  ccr_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_seq_top dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
        .insn_done(insn_done), .rte_req(rte_req), .irq_ack(irq_ack),
        .ack_vec(ack_vec), .pc_in(pc_in), .ccr_in(ccr_in), .pc_out(pc_out),
        .pc_load(pc_load), .ccr_out(ccr_out), .ccr_load(ccr_load),
        .sp_wr(sp_wr), .sp_wdata(sp_wdata), .sp_out(sp_out),
        .align_err(align_err), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    // Model state
    int          ph;            // 0 idle,1 push pc,2 push ccr,3 vector,4 pop ccr,5 pop pc
    logic [15:0] m_sp, m_pc_s, m_pc_o;
    logic [7:0]  m_ccr_s, m_ccr_o;
    logic [5:0]  m_vec;
    bit          m_load, m_err;
    string       res_tag;
    logic [15:0] mem [int];
    bit [31:0]   rs = 32'h1234_abcd;

    function automatic int unsigned rnd();
        rs ^= rs << 13;
        rs ^= rs >> 17;
        rs ^= rs << 5;
        return rs;
    endfunction

    function automatic logic [15:0] rd(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return (a * 16'd7) ^ 16'h3c5a;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                     compared, mismatched);
            $finish;
        end
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        #(4 * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        report();
    end

    // Expected memory-port values for the current model phase.
    function automatic logic [15:0] exp_addr();
        case (ph)
            1, 2, 4, 5: return m_sp;
            3:          return {9'b0, m_vec, 1'b0};
            default:    return 16'h0;
        endcase
    endfunction

    initial begin
        rst_n = 0; irq_req = 0; irq_vec = 0; insn_done = 0; rte_req = 0;
        sp_wr = 0; sp_wdata = 0; pc_in = 0; ccr_in = 0; mem_rdy = 0;
        mem_rdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "pc_load", pc_load, 0);
        chk("R1", "ccr_load", ccr_load, 0);
        chk("R1", "irq_ack", irq_ack, 0);
        chk("R1", "align_err", align_err, 0);
        chk("R1", "pc_out", pc_out, 0);
        chk("R1", "ccr_out", ccr_out, 0);
        chk("R1", "sp_out", sp_out, 16'h0400);
        ph = 0; m_sp = 16'h0400; m_pc_s = 0; m_pc_o = 0; m_ccr_s = 0;
        m_ccr_o = 0; m_vec = 0; m_load = 0; m_err = 0; res_tag = "R5";
        rst_n = 1;
        for (int mode = 0; mode < 4; mode++) begin
            for (int cyc = 0; cyc < 1500; cyc++) begin
                logic [15:0] ea;
                bit          act, wr;
                string       mtag;
                // Drive inputs for this cycle.
                irq_req   = (rnd() % 3) == 0;
                irq_vec   = 6'(rnd());
                insn_done = (rnd() % 2) == 0;
                rte_req   = (rnd() % (mode == 3 ? 4 : 10)) == 0;
                sp_wr     = (rnd() % 12) == 0;
                sp_wdata  = 16'h0100 + 16'(rnd() % 16'h0e00);
                if ((rnd() % 4) != 0) sp_wdata[0] = 1'b0;
                pc_in     = 16'(rnd()) & 16'hfffe;
                ccr_in    = 8'(rnd());
                case (mode)
                    0:       mem_rdy = 1'b1;
                    1:       mem_rdy = (rnd() % 2) == 0;
                    default: mem_rdy = (rnd() % 4) == 0;
                endcase
                ea  = exp_addr();
                act = (ph != 0);
                wr  = (ph == 1) || (ph == 2);
                mem_rdata = (act && !wr) ? rd(ea) : 16'(rnd());
                #1;
                // Compare against the model.
                case (ph)
                    1: mtag = "R3";
                    2: mtag = "R4";
                    3: mtag = "R5";
                    4, 5: mtag = "R7";
                    default: mtag = "R9";
                endcase
                if (act && !mem_rdy) mtag = "R9";
                chk("R2", "irq_ack", irq_ack,
                    ph == 0 && !rte_req && irq_req && insn_done);
                chk("R2", "ack_vec", ack_vec,
                    (ph == 0 && !rte_req && irq_req && insn_done) ? irq_vec : 6'd0);
                chk("R11", "busy", busy, act);
                chk(mtag, "mem_req", mem_req, act);
                chk(mtag, "mem_we", mem_we, wr);
                chk(mtag, "mem_addr", mem_addr, ea);
                chk(mtag, "mem_wdata", mem_wdata,
                    ph == 1 ? m_pc_s : (ph == 2 ? {8'h0, m_ccr_s} : 16'h0));
                chk(res_tag, "pc_load", pc_load, m_load);
                chk(res_tag, "pc_out", pc_out, m_pc_o);
                chk("R6", "ccr_load", ccr_load, m_load);
                chk(res_tag == "R5" ? "R6" : "R7", "ccr_out", ccr_out, m_ccr_o);
                chk("R10", "sp_out", sp_out, m_sp);
                chk("R8", "align_err", align_err, m_err);
                // Advance the model across the coming clock edge.
                m_load = 0;
                case (ph)
                    0: begin
                        if (rte_req) begin
                            m_err |= m_sp[0]; m_sp[0] = 1'b0; ph = 4;
                        end else if (irq_req && insn_done) begin
                            m_err |= m_sp[0]; m_sp[0] = 1'b0;
                            m_sp = m_sp - 16'd2;
                            m_pc_s = pc_in; m_ccr_s = ccr_in; m_vec = irq_vec;
                            ph = 1;
                        end else if (sp_wr) begin
                            m_sp = sp_wdata;
                        end
                    end
                    1: if (mem_rdy) begin
                        mem[int'(ea)] = m_pc_s; m_sp = m_sp - 16'd2; ph = 2;
                    end
                    2: if (mem_rdy) begin
                        mem[int'(ea)] = {8'h0, m_ccr_s}; ph = 3;
                    end
                    3: if (mem_rdy) begin
                        m_pc_o = mem_rdata; m_ccr_o = m_ccr_s | 8'h80;
                        m_load = 1; res_tag = "R5"; ph = 0;
                    end
                    4: if (mem_rdy) begin
                        m_ccr_s = mem_rdata[7:0]; m_sp = m_sp + 16'd2; ph = 5;
                    end
                    5: if (mem_rdy) begin
                        m_pc_o = mem_rdata; m_ccr_o = m_ccr_s; m_load = 1;
                        res_tag = "R7"; m_sp = m_sp + 16'd2; ph = 0;
                    end
                    default: ph = 0;
                endcase
                @(negedge clk);
            end
        end
        report();
    end

endmodule